// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external machine cycle each time it is asked to, on a bus where the low address byte and the data byte share the same wires at different times. A separate set of lines carries the high address byte. A requester presents a start strobe together with a cycle type, an address and write data. The sequencer then steps through its clock states. While it does so it drives the address latch strobe, the active-low read and write strobes, the memory/I/O select and a two-bit status code. It switches the shared lines between address and data use.

Read data is taken from the shared lines at the end of the third state and returned with a one-cycle done pulse. A slow device can hold the cycle in wait states by keeping ready low. An external bus master can take the bus with a hold request, but it only gets the bus between machine cycles. The shared lines are modelled as separate in, out and output-enable ports, and the pad logic at the chip edge combines them.

Top module: `bus_cycle_seq`

## Requirements
- R1: In the first state (T1) the latch strobe `ale_o` is high for exactly that one cycle, `ad_oe_o` is high, `ad_o` carries the low address byte and `a_hi_o` carries the high address byte. `ale_o` is never high in any other state.
- R2: For read-type cycles (fetch, memory read, I/O read), `ad_oe_o` is low from T2 onward and `rd_n_o` is low in T2, in every wait state and in T3. `ad_i` is sampled at the end of T3 and appears on `rdata_o` while `done_o` is high. `rd_n_o` and `wr_n_o` are never low together.
- R3: For write cycles, `ad_o` carries the write data with `ad_oe_o` high, and `wr_n_o` is low, from T2 through T3.
- R4: A fetch lasts four states; in the fourth state, T4, both strobes are high and the shared lines are released. The other cycle types last three states. `done_o` is a single-cycle pulse in the cycle after the last state. The sequencer then rests for at least one idle cycle, with `ale_o` low.
- R5: The cycle type is given on `ctype_i`: 0 is fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. `stat_o` reads 11 for a fetch, 10 for a read and 01 for a write, from T1 through the last state. It reads 00 when no cycle is running.
- R6: `io_m_o` is 1 during I/O cycles and 0 during memory cycles. In an I/O cycle the 8-bit port number (address bits 7:0) appears on `a_hi_o` and also on `ad_o` in T1.
- R7: `ready_i` is sampled at the end of T2 and at the end of each wait state. Each low sample inserts one wait state, and that wait state repeats the T2 levels of every output.
- R8: When `hold_req_i` is high in an idle cycle, `hlda_o` goes high in the next cycle. While `hlda_o` is high, `ad_oe_o` and `a_hi_oe_o` are low and both strobes are high. `hlda_o` falls in the cycle after `hold_req_i` is low. A hold request takes priority over a start seen in the same idle cycle.
- R9: A hold request that arrives during a machine cycle does not shorten or interrupt it. `hlda_o` rises only after the done cycle.
- R10: A start is ignored when it arrives while a cycle is running, while the bus is held, or with a type code of 5 to 7. In each of these cases no T1 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one machine cycle |
| ctype_i | input | 3 | Cycle type code |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Data for write cycles |
| ready_i | input | 1 | Device ready; low inserts wait states |
| hold_req_i | input | 1 | External request for the bus |
| ad_i | input | 8 | Shared lines, input side |
| a_hi_o | output | 8 | High address byte |
| a_hi_oe_o | output | 1 | Enable for the high address lines |
| ad_o | output | 8 | Shared lines, output side |
| ad_oe_o | output | 1 | Enable for the shared lines |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| stat_o | output | 2 | Cycle status code |
| hlda_o | output | 1 | Hold acknowledge |
| rdata_o | output | 8 | Data captured by the last read-type cycle |
| done_o | output | 1 | One-cycle pulse when a cycle completes |

## Verification
Seeded random cycles mix all five types with random addresses, data and zero to three wait states. This separates the fetch length from the three-state length, read strobe behaviour from write strobe behaviour, and memory addressing from the duplicated I/O port byte. Directed cases cover the situations that random requests rarely produce: a hold request in an idle cycle, a hold request arriving mid-cycle, hold against start in the same cycle, a start while held, a start while busy, and unused type codes. These cases tell whether bus hand-over waits for the cycle boundary and whether stray starts are really dropped.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TW, S_T3, S_T4, S_HOLD
  } bcs_state_e;

  localparam logic [2:0] CT_FETCH = 3'd0;
  localparam logic [2:0] CT_MRD   = 3'd1;
  localparam logic [2:0] CT_MWR   = 3'd2;
  localparam logic [2:0] CT_IORD  = 3'd3;
  localparam logic [2:0] CT_IOWR  = 3'd4;

  localparam logic [1:0] ST_NONE  = 2'b00;
  localparam logic [1:0] ST_WRITE = 2'b01;
  localparam logic [1:0] ST_READ  = 2'b10;
  localparam logic [1:0] ST_FETCH = 2'b11;

  typedef struct packed {
    logic       fetch;
    logic       rd;
    logic       wr;
    logic       io;
    logic [1:0] stat;
  } bcs_kind_t;
endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
(
  input  logic [2:0] ctype,
  output logic       valid,
  output bcs_kind_t  kind
);
  always_comb begin
    valid = 1'b1;
    kind  = '0;
    unique case (ctype)
      CT_FETCH: begin kind.fetch = 1'b1; kind.rd = 1'b1; kind.stat = ST_FETCH; end
      CT_MRD:   begin kind.rd = 1'b1; kind.stat = ST_READ; end
      CT_MWR:   begin kind.wr = 1'b1; kind.stat = ST_WRITE; end
      CT_IORD:  begin kind.rd = 1'b1; kind.io = 1'b1; kind.stat = ST_READ; end
      CT_IOWR:  begin kind.wr = 1'b1; kind.io = 1'b1; kind.stat = ST_WRITE; end
      default:  valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          req_valid,
  input  bcs_kind_t     req_kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          ready,
  input  logic          hold_req,
  input  logic [DW-1:0] ad_in,
  output bcs_state_e    state,
  output bcs_kind_t     kind,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          done_q
);
  bcs_state_e state_q, state_d;
  logic       accept;

  assign accept = (state_q == S_IDLE) && !hold_req && start && req_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (hold_req)    state_d = S_HOLD;
        else if (accept) state_d = S_T1;
      end
      S_T1:    state_d = S_T2;
      S_T2,
      S_TW:    state_d = ready ? S_T3 : S_TW;
      S_T3:    state_d = kind.fetch ? S_T4 : S_IDLE;
      S_T4:    state_d = S_IDLE;
      S_HOLD:  state_d = hold_req ? S_HOLD : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      kind    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ((state_q == S_T3) && !kind.fetch) || (state_q == S_T4);
      if (accept) begin
        kind    <= req_kind;
        addr_q  <= addr;
        wdata_q <= wdata;
      end
      if ((state_q == S_T3) && kind.rd)
        rdata_q <= ad_in;
    end
  end

  assign state = state_q;

  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE && state_q != S_HOLD) |=> (state_q != S_HOLD)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R4
  AST_T1_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_HOLD) |=> (state_q != S_T1)); // R10
endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  bcs_state_e      state,
  input  bcs_kind_t       kind,
  input  logic [AW-1:0]   addr_q,
  input  logic [DW-1:0]   wdata_q,
  output logic [AW-DW-1:0] a_hi,
  output logic            a_hi_oe,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            io_m,
  output logic [1:0]      stat
);
  localparam int HIW = AW - DW;

  logic in_cycle, data_phase;

  assign in_cycle   = (state == S_T1) || (state == S_T2) || (state == S_TW) ||
                      (state == S_T3) || (state == S_T4);
  assign data_phase = (state == S_T2) || (state == S_TW) || (state == S_T3);

  always_comb begin
    a_hi    = kind.io ? HIW'(addr_q[DW-1:0]) : addr_q[AW-1:DW];
    a_hi_oe = (state != S_HOLD);
    ad_out  = (state == S_T1) ? addr_q[DW-1:0] : wdata_q;
    ad_oe   = (state == S_T1) || (kind.wr && data_phase);
    ale     = (state == S_T1);
    rd_n    = !(kind.rd && data_phase);
    wr_n    = !(kind.wr && data_phase);
    io_m    = in_cycle && kind.io;
    stat    = in_cycle ? kind.stat : ST_NONE;
  end

  AST_WAIT_REPEATS_T2: assert property (@(posedge clk) disable iff (rst)
    (state == S_TW) |-> ($stable(rd_n) && $stable(wr_n) && $stable(ad_oe) &&
                         $stable(ad_out) && $stable(stat))); // R7
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       ctype_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ready_i,
  input  logic             hold_req_i,
  input  logic [DW-1:0]    ad_i,
  output logic [AW-DW-1:0] a_hi_o,
  output logic             a_hi_oe_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             io_m_o,
  output logic [1:0]       stat_o,
  output logic             hlda_o,
  output logic [DW-1:0]    rdata_o,
  output logic             done_o
);
  logic          req_valid;
  bcs_kind_t     req_kind, kind;
  bcs_state_e    state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  bcs_decode u_dec (
    .ctype (ctype_i),
    .valid (req_valid),
    .kind  (req_kind)
  );

  bcs_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start_i),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .addr      (addr_i),
    .wdata     (wdata_i),
    .ready     (ready_i),
    .hold_req  (hold_req_i),
    .ad_in     (ad_i),
    .state     (state),
    .kind      (kind),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rdata_o),
    .done_q    (done_o)
  );

  bcs_drive #(.AW(AW), .DW(DW)) u_drv (
    .clk     (clk),
    .rst     (rst),
    .state   (state),
    .kind    (kind),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .a_hi    (a_hi_o),
    .a_hi_oe (a_hi_oe_o),
    .ad_out  (ad_o),
    .ad_oe   (ad_oe_o),
    .ale     (ale_o),
    .rd_n    (rd_n_o),
    .wr_n    (wr_n_o),
    .io_m    (io_m_o),
    .stat    (stat_o)
  );

  assign hlda_o = (state == S_HOLD);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ale_o |=> !ale_o); // R1
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (rd_n_o || wr_n_o)); // R2
  AST_HOLD_FLOATS: assert property (@(posedge clk) disable iff (rst)
    hlda_o |-> (!ad_oe_o && !a_hi_oe_o && rd_n_o && wr_n_o)); // R8
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (rd_n_o && wr_n_o && !ale_o)); // R4
endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start_i, ready_i, hold_req_i;
  logic [2:0]  ctype_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i, ad_i, a_hi_o, ad_o, rdata_o;
  logic a_hi_oe_o, ad_oe_o, ale_o, rd_n_o, wr_n_o, io_m_o, hlda_o, done_o;
  logic [1:0] stat_o;

  int checks = 0;
  int errors = 0;

  bus_cycle_seq u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .ctype_i(ctype_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ready_i(ready_i), .hold_req_i(hold_req_i), .ad_i(ad_i),
    .a_hi_o(a_hi_o), .a_hi_oe_o(a_hi_oe_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .io_m_o(io_m_o),
    .stat_o(stat_o), .hlda_o(hlda_o), .rdata_o(rdata_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_stat(input logic [2:0] t);
    case (t)
      3'd0: return 2'b11;
      3'd1, 3'd3: return 2'b10;
      default: return 2'b01;
    endcase
  endfunction
  function automatic bit is_rd(input logic [2:0] t); return t == 0 || t == 1 || t == 3; endfunction
  function automatic bit is_wr(input logic [2:0] t); return t == 2 || t == 4; endfunction
  function automatic bit is_io(input logic [2:0] t); return t == 3 || t == 4; endfunction
  function automatic logic [7:0] exp_hi(input logic [2:0] t, input logic [15:0] a);
    return is_io(t) ? a[7:0] : a[15:8];
  endfunction

  task automatic data_phase_chk(input logic [2:0] t, input logic [7:0] wd, input string tag);
    chk("R2", {tag, " rd_n"}, rd_n_o, !is_rd(t));
    chk("R3", {tag, " wr_n"}, wr_n_o, !is_wr(t));
    chk("R2", {tag, " ad_oe"}, ad_oe_o, is_wr(t));
    if (is_wr(t)) chk("R3", {tag, " wdata"}, ad_o, wd);
    chk("R5", {tag, " stat"}, stat_o, exp_stat(t));
    chk("R1", {tag, " ale low"}, ale_o, 1'b0);
    chk("R9", {tag, " hlda"}, hlda_o, 1'b0);
  endtask

  task automatic run_cycle(input logic [2:0] t, input logic [15:0] a, input logic [7:0] wd,
                           input logic [7:0] rd, input int waits, input bit hold_mid,
                           input bit busy_start);
    @(negedge clk);
    start_i = 1; ctype_i = t; addr_i = a; wdata_i = wd; ready_i = 1; hold_req_i = 0;
    @(negedge clk);
    start_i = 0; ad_i = rd; ready_i = (waits == 0);
    chk("R1", "T1 ale", ale_o, 1'b1);
    chk("R1", "T1 ad_oe", ad_oe_o, 1'b1);
    chk("R6", "T1 ad addr/port", ad_o, a[7:0]);
    chk("R6", "T1 a_hi", a_hi_o, exp_hi(t, a));
    chk("R5", "T1 stat", stat_o, exp_stat(t));
    chk("R6", "T1 io_m", io_m_o, is_io(t));
    if (hold_mid) hold_req_i = 1;
    @(negedge clk);
    ready_i = (waits == 0);
    data_phase_chk(t, wd, "T2");
    if (busy_start) begin start_i = 1; ctype_i = 3'd1; addr_i = ~a; end
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      ready_i = (i == waits - 1);
      data_phase_chk(t, wd, "TW R7");
    end
    @(negedge clk);
    start_i = 0;
    data_phase_chk(t, wd, "T3");
    if (t == 3'd0) begin
      @(negedge clk);
      chk("R4", "T4 rd_n", rd_n_o, 1'b1);
      chk("R4", "T4 ad_oe", ad_oe_o, 1'b0);
      chk("R5", "T4 stat", stat_o, 2'b11);
      chk("R4", "T4 done", done_o, 1'b0);
    end
    @(negedge clk);
    chk("R4", "done pulse", done_o, 1'b1);
    chk("R5", "idle stat", stat_o, 2'b00);
    chk("R9", "hlda after cycle", hlda_o, 1'b0);
    if (is_rd(t)) chk("R2", "rdata", rdata_o, rd);
    @(negedge clk);
    if (hold_mid) begin
      chk("R9", "hlda at boundary", hlda_o, 1'b1);
      chk("R8", "ad_oe in hold", ad_oe_o, 1'b0);
      chk("R8", "a_hi_oe in hold", a_hi_oe_o, 1'b0);
      hold_req_i = 0;
      @(negedge clk);
      chk("R8", "hlda release", hlda_o, 1'b0);
    end else begin
      chk("R4", "done single", done_o, 1'b0);
      chk(busy_start ? "R10" : "R4", "no new T1", ale_o, 1'b0);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'h0BC5_1234);
    rst = 1; start_i = 0; ctype_i = 0; addr_i = 0; wdata_i = 0;
    ready_i = 1; hold_req_i = 0; ad_i = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R5", "reset stat", stat_o, 2'b00);
    chk("R1", "reset ale", ale_o, 1'b0);
    chk("R2", "reset rd_n", rd_n_o, 1'b1);
    chk("R3", "reset wr_n", wr_n_o, 1'b1);
    chk("R8", "reset hlda", hlda_o, 1'b0);
    chk("R4", "reset done", done_o, 1'b0);

    // directed: each type, with and without waits
    run_cycle(3'd0, 16'h1234, 8'h00, 8'hA5, 0, 0, 0);
    run_cycle(3'd1, 16'hBEEF, 8'h00, 8'h3C, 2, 0, 0);
    run_cycle(3'd2, 16'h8001, 8'h77, 8'h00, 0, 0, 0);
    run_cycle(3'd3, 16'hFF42, 8'h00, 8'hC3, 1, 0, 0);
    run_cycle(3'd4, 16'h0099, 8'h5A, 8'h00, 3, 0, 0);
    // R9: hold arrives mid-cycle
    run_cycle(3'd1, 16'h4444, 8'h00, 8'h11, 1, 1, 0);
    // R10: start while busy
    run_cycle(3'd2, 16'h2222, 8'hEE, 8'h00, 0, 0, 1);

    // R10: unused type codes
    for (int c = 5; c < 8; c++) begin
      @(negedge clk); start_i = 1; ctype_i = c[2:0];
      @(negedge clk); start_i = 0;
      chk("R10", "bad code no T1", ale_o, 1'b0);
      chk("R10", "bad code stat", stat_o, 2'b00);
    end

    // R8: hold beats start in the same idle cycle; start while held ignored
    @(negedge clk); hold_req_i = 1; start_i = 1; ctype_i = 3'd1;
    @(negedge clk); start_i = 0;
    chk("R8", "hold priority hlda", hlda_o, 1'b1);
    chk("R8", "hold priority ale", ale_o, 1'b0);
    start_i = 1;
    @(negedge clk); start_i = 0;
    chk("R10", "start in hold ale", ale_o, 1'b0);
    chk("R8", "hold kept", hlda_o, 1'b1);
    chk("R8", "hold rd_n", rd_n_o, 1'b1);
    hold_req_i = 0;
    @(negedge clk);
    chk("R8", "hold dropped", hlda_o, 1'b0);
    @(negedge clk);
    chk("R10", "no late T1", ale_o, 1'b0);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [2:0] t;
      t = 3'($urandom_range(0, 4));
      run_cycle(t, 16'($urandom), 8'($urandom), 8'($urandom),
                int'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0), 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule